// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting timer channel. A one-cycle load strobe delivers a new initial count and a 3-bit mode. The channel then produces one of six output waveforms on a single line. It advances only on cycles where the clock-enable input is high, and a gate input either suspends counting or retriggers it, depending on the mode. The live count value and the output level are exposed so that a surrounding bus interface can latch and read them.

The surrounding logic owns byte sequencing, control-word decoding and read-back. This channel sees only complete 16-bit counts and a 3-bit mode code. Counting is always binary.

An "active tick" is a cycle in which the clock-enable is high, no restart occurs and the gate permits counting. N is the loaded count after zero is mapped to 65536. "Restart" means the live count returns to its start value, which is N, or the square-wave high-half value in mode 3. A restart cycle is not itself counted.

Top module: `interval_counter_ch`

## Requirements
- R1: A load value of 0 sets N = 65536: the count reads 0x0000 after the load, then 0xFFFF, and the mode-0 output rises only after 65536 active ticks.
- R2: A load (load_i high for one cycle) restarts the channel in the next cycle with the new N and mode. In all modes except 3 and 7 the count then equals the loaded value. A load takes priority over a simultaneous gate edge.
- R3: Mode 0 (code 0): the output is low after restart, goes high after N active ticks, and stays high until the next load.
- R4: Mode 1 (code 1): the output is low after restart and goes high after N active ticks, where every enabled cycle counts regardless of the gate level. A gate rising edge restarts the channel.
- R5: Mode 2 (code 2): the count runs N, N-1, ..., 1 and then reloads N. On each reload the output is high for one active tick and low otherwise, indefinitely.
- R6: Mode 3 (code 3): the output is high for (N+1)/2 ticks and low for N/2 ticks of every N-tick period, and the count steps down by two. The high half starts at N (N+1 when N is odd) and the low half starts at N (N-1 when N is odd). With N = 1 the output stays high.
- R7: Modes 4 and 5 (codes 4, 5): the output is low until N active ticks have elapsed, is high for exactly one active tick, and then stays low.
- R8: A gate rising edge restarts the channel in modes 1, 2, 3 and 5 and has no effect in modes 0 and 4.
- R9: A low gate suspends counting in modes 0, 2, 3 and 4 and has no effect in modes 1 and 5.
- R10: With clock-enable low, neither the count nor the output changes, except through a restart.
- R11: After reset the channel is in mode 3 with N = 65536, the count reads 0x0000 and the output is high.
- R12: Mode codes 6 and 7 behave exactly as codes 2 and 3.
- R13: In modes 0, 1, 4 and 5 the count keeps decrementing past expiry, wrapping modulo 65536, without producing further output transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| tick_en_i | input | 1 | Count enable; one active tick per high cycle |
| gate_i | input | 1 | Gate level (suspend or retrigger, mode dependent) |
| load_i | input | 1 | Load strobe for count and mode |
| load_val_i | input | 16 | New initial count (0 means 65536) |
| load_mode_i | input | 3 | New mode code 0..7 |
| count_o | output | 16 | Live count value |
| out_o | output | 1 | Channel output line |

## Verification
The assertions assume synchronous inputs that are free of X after reset. They do not assume that load strobes are spaced apart or that the gate is held steady. The properties' antecedents exclude load cycles and gate rising edges wherever these would legitimately override the checked behaviour. The stimulus therefore drives loads back to back, toggles the gate during counting, and holds clock-enable low for stretches. It stays inside these assumptions by changing inputs only between clock edges and never leaving any input undriven after reset.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

    localparam int CNT_W  = 16;
    localparam int N_W    = CNT_W + 1;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        M_TERM    = 3'd0,
        M_ONESHOT = 3'd1,
        M_RATE    = 3'd2,
        M_SQUARE  = 3'd3,
        M_SWSTB   = 3'd4,
        M_HWSTB   = 3'd5
    } mode_e;

    typedef struct packed {
        logic [N_W-1:0]   n;
        mode_e            mode;
        logic [CNT_W-1:0] cnt;
        logic             out;
        logic             done;
        logic             gate;
    } chan_s;

    // codes 6 and 7 fold onto the periodic modes 2 and 3
    function automatic mode_e fold_mode(logic [MODE_W-1:0] m);
        if (m[2] && m[1]) begin
            return mode_e'({1'b0, m[1:0]});
        end
        return mode_e'(m);
    endfunction

endpackage

// File: rtl/ictr_trigger.sv
module ictr_trigger
    import ictr_pkg::*;
(
    input  mode_e mode_q,
    input  logic  gate_i,
    input  logic  gate_q,
    input  logic  tick_en_i,
    input  logic  load_i,
    output logic  restart_o,
    output logic  step_o
);

    logic retrig_mode;
    logic free_run;
    logic gate_rise;

    always_comb begin
        retrig_mode = (mode_q == M_ONESHOT) || (mode_q == M_RATE) ||
                      (mode_q == M_SQUARE)  || (mode_q == M_HWSTB);
        free_run    = (mode_q == M_ONESHOT) || (mode_q == M_HWSTB);
        gate_rise   = gate_i && !gate_q;
        restart_o   = load_i || (gate_rise && retrig_mode);
        step_o      = tick_en_i && !restart_o && (free_run || gate_i);
    end

endmodule

// File: rtl/ictr_reload.sv
module ictr_reload
    import ictr_pkg::*;
(
    input  logic [N_W-1:0]   n_i,
    input  mode_e            mode_i,
    output logic [CNT_W-1:0] start_o,
    output logic [CNT_W-1:0] hi_o,
    output logic [CNT_W-1:0] lo_o
);

    logic [N_W-1:0] hi_full;
    logic [N_W-1:0] lo_full;

    always_comb begin
        hi_full = n_i[0] ? n_i + N_W'(1) : n_i;
        lo_full = n_i[0] ? n_i - N_W'(1) : n_i;
        hi_o    = hi_full[CNT_W-1:0];
        lo_o    = lo_full[CNT_W-1:0];
        start_o = (mode_i == M_SQUARE) ? hi_o : n_i[CNT_W-1:0];
    end

endmodule

// File: rtl/interval_counter_ch.sv
module interval_counter_ch
    import ictr_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_en_i,
    input  logic             gate_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [MODE_W-1:0] load_mode_i,
    output logic [CNT_W-1:0] count_o,
    output logic             out_o
);

    localparam logic [N_W-1:0]   N_MAX = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO   = CNT_W'(2);

    chan_s            st_d, st_q;
    logic [N_W-1:0]   n_new, n_sel;
    mode_e            mode_sel;
    logic             restart, step;
    logic [CNT_W-1:0] start_cnt, hi_cnt, lo_cnt;

    always_comb begin
        n_new    = (load_val_i == '0) ? N_MAX : {1'b0, load_val_i};
        n_sel    = load_i ? n_new : st_q.n;
        mode_sel = load_i ? fold_mode(load_mode_i) : st_q.mode;
    end

    ictr_trigger u_trig (
        .mode_q    (st_q.mode),
        .gate_i    (gate_i),
        .gate_q    (st_q.gate),
        .tick_en_i (tick_en_i),
        .load_i    (load_i),
        .restart_o (restart),
        .step_o    (step)
    );

    ictr_reload u_rel (
        .n_i     (n_sel),
        .mode_i  (mode_sel),
        .start_o (start_cnt),
        .hi_o    (hi_cnt),
        .lo_o    (lo_cnt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.gate = gate_i;
        if (restart) begin
            st_d.n    = n_sel;
            st_d.mode = mode_sel;
            st_d.cnt  = start_cnt;
            st_d.out  = (mode_sel == M_SQUARE);
            st_d.done = 1'b0;
        end else if (step) begin
            unique case (st_q.mode)
                M_TERM, M_ONESHOT: begin
                    st_d.cnt = st_q.cnt - ONE;
                    if (st_q.cnt == ONE && !st_q.done) begin
                        st_d.out  = 1'b1;
                        st_d.done = 1'b1;
                    end
                end
                M_RATE: begin
                    if (st_q.cnt == ONE) begin
                        st_d.cnt = st_q.n[CNT_W-1:0];
                        st_d.out = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                        st_d.out = 1'b0;
                    end
                end
                M_SQUARE: begin
                    if (st_q.cnt == TWO) begin
                        if (st_q.out && st_q.n != N_W'(1)) begin
                            st_d.out = 1'b0;
                            st_d.cnt = lo_cnt;
                        end else begin
                            st_d.out = 1'b1;
                            st_d.cnt = hi_cnt;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt - TWO;
                    end
                end
                default: begin
                    st_d.cnt = st_q.cnt - ONE;
                    if (st_q.cnt == ONE && !st_q.done) begin
                        st_d.out  = 1'b1;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.out  = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.n    <= N_MAX;
            st_q.mode <= M_SQUARE;
            st_q.cnt  <= '0;
            st_q.out  <= 1'b1;
            st_q.done <= 1'b0;
            st_q.gate <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign out_o   = st_q.out;

    AST_CE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_en_i && !load_i && !gate_i) |=> ($stable(count_o) && $stable(out_o))); // R10

    AST_LOAD_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && load_mode_i[1:0] != 2'b11) |=> (count_o == $past(load_val_i))); // R2

    AST_TERM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode == M_TERM && out_o && !load_i) |=> out_o); // R3

    AST_SQUARE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode == M_SQUARE && tick_en_i && gate_i && st_q.gate && !load_i && count_o != TWO)
        |=> (count_o == $past(count_o) - TWO)); // R6

    AST_STROBE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.mode == M_SWSTB || st_q.mode == M_HWSTB) && out_o && tick_en_i &&
         gate_i && st_q.gate && !load_i) |=> !out_o); // R7

    AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode == M_TERM && !gate_i && !load_i) |=> $stable(count_o)); // R9

endmodule

// File: tb/sim_interval_counter_ch.sv
module sim_interval_counter_ch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0;
    logic        gate = 1'b0;
    logic        load = 1'b0;
    logic [15:0] lval = '0;
    logic [2:0]  lmode = '0;
    logic [15:0] count;
    logic        out;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    string tag      = "R11";
    bit    done     = 1'b0;

    // reference model state
    longint m_n = 65536;
    int     m_mode = 3;
    longint m_d = 0;
    bit     m_pg = 1'b0;

    always #5 clk = ~clk;

    interval_counter_ch u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_en_i   (ce),
        .gate_i      (gate),
        .load_i      (load),
        .load_val_i  (lval),
        .load_mode_i (lmode),
        .count_o     (count),
        .out_o       (out)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_n = 65536; m_mode = 3; m_d = 0; m_pg = 1'b0;
        end else begin
            bit rise;
            bit retrig;
            bit freerun;
            rise    = gate && !m_pg;
            retrig  = (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5);
            freerun = (m_mode == 1 || m_mode == 5);
            if (load) begin
                m_n    = (lval == 0) ? 65536 : longint'(lval);
                m_mode = (lmode >= 6) ? int'(lmode) - 4 : int'(lmode);
                m_d    = 0;
            end else if (rise && retrig) begin
                m_d = 0;
            end else if (ce && (freerun || gate)) begin
                m_d = m_d + 1;
            end
            m_pg = gate;
        end
    end

    function automatic bit exp_out();
        longint p;
        case (m_mode)
            0, 1: return m_d >= m_n;
            2: return (m_d > 0) && (m_d % m_n == 0);
            3: begin
                p = m_d % m_n;
                return p < (m_n + 1) / 2;
            end
            default: return m_d == m_n;
        endcase
    endfunction

    function automatic logic [15:0] exp_cnt();
        longint p, hi, lo, hl;
        case (m_mode)
            2: begin
                p = m_d % m_n;
                return (p == 0) ? 16'(m_n) : 16'(m_n - p);
            end
            3: begin
                p  = m_d % m_n;
                hl = (m_n + 1) / 2;
                hi = (m_n % 2 == 1) ? m_n + 1 : m_n;
                lo = (m_n % 2 == 1) ? m_n - 1 : m_n;
                return (p < hl) ? 16'(hi - 2 * p) : 16'(lo - 2 * (p - hl));
            end
            default: return 16'(m_n - m_d);
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (count !== exp_cnt() || out !== exp_out()) begin
                n_fail++;
                $display("FAIL %s count=%h exp=%h out=%b exp=%b", tag, count, exp_cnt(), out, exp_out());
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog count=%h exp=done out=%b exp=done", count, out);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_load(logic [15:0] v, logic [2:0] m);
        lval = v; lmode = m; load = 1'b1;
        run(1);
        load = 1'b0;
    endtask

    task automatic set_gate(bit g);
        gate = g;
        run(1);
    endtask

    initial begin
        run(3);
        rst_n = 1'b1;
        run(1);
        // R11 explicit reset-state check
        n_checks++;
        if (count !== 16'h0000 || out !== 1'b1) begin
            n_fail++;
            $display("FAIL R11 count=%h exp=0000 out=%b exp=1", count, out);
        end
        run(3);

        tag = "R3";  gate = 1'b1; ce = 1'b1;
        do_load(16'd5, 3'd0); run(8);
        tag = "R13"; run(12);
        tag = "R10"; do_load(16'd6, 3'd0);
        for (int i = 0; i < 20; i++) begin ce = (i % 3 != 0); run(1); end
        ce = 1'b0; run(5); ce = 1'b1;
        tag = "R9";  do_load(16'd7, 3'd0); run(2); gate = 1'b0; run(5); gate = 1'b1; run(8);
        do_load(16'd6, 3'd4); run(2); gate = 1'b0; run(4); gate = 1'b1; run(8);
        do_load(16'd6, 3'd1); run(2); gate = 1'b0; run(8); gate = 1'b1; run(2);
        do_load(16'd4, 3'd5); gate = 1'b0; run(8);
        tag = "R4";  do_load(16'd4, 3'd1); run(2); set_gate(1'b0); set_gate(1'b1); run(7);
        set_gate(1'b0); run(2); set_gate(1'b1); run(3);
        tag = "R5";  gate = 1'b1; do_load(16'd3, 3'd2); run(12);
        do_load(16'd1, 3'd2); run(5);
        gate = 1'b0; run(4); gate = 1'b1; run(6);
        tag = "R6";  do_load(16'd5, 3'd3); run(17);
        do_load(16'd4, 3'd3); run(13);
        do_load(16'd1, 3'd3); run(5);
        do_load(16'd2, 3'd3); run(7);
        gate = 1'b0; run(3); gate = 1'b1; run(7);
        tag = "R7";  do_load(16'd3, 3'd4); run(10);
        do_load(16'd3, 3'd5); run(8); set_gate(1'b0); set_gate(1'b1); run(8);
        tag = "R8";  do_load(16'd9, 3'd0); run(3); set_gate(1'b0); set_gate(1'b1); run(10);
        do_load(16'd9, 3'd4); run(3); set_gate(1'b0); set_gate(1'b1); run(10);
        do_load(16'd5, 3'd3); run(3); set_gate(1'b0); set_gate(1'b1); run(6);
        do_load(16'd5, 3'd2); run(3); set_gate(1'b0); set_gate(1'b1); run(6);
        tag = "R12"; do_load(16'd3, 3'd6); run(10);
        do_load(16'd5, 3'd7); run(14);
        tag = "R2";  do_load(16'd20, 3'd0); run(5); do_load(16'd4, 3'd0); run(6);
        do_load(16'd8, 3'd1); do_load(16'd3, 3'd2); run(4);
        gate = 1'b0; run(1);
        lval = 16'd6; lmode = 3'd3; load = 1'b1; gate = 1'b1; run(1); load = 1'b0; run(8);
        tag = "R1";  do_load(16'd0, 3'd3); run(10);
        do_load(16'd0, 3'd0); run(65540);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule